// File: doc/BRIEF.md
# Redundant Result Checker and Voter

This block sits between the execute stage and write-back of a wide-issue pipeline that runs every instruction two or three times for fault tolerance. Each cycle it receives the results of the execute lanes, each tagged with the program slot and the bundle sequence number of the instruction that produced it. A routing control word tells each checker which copies to judge. A copy can come from a live lane or from a small hold store. The hold store keeps results whose partner copies run in a later time slot.

A run-time mode input picks duplicate comparison or triple majority voting. Each checker that has all the copies it needs either commits one result or reports that none can be trusted. The result lands on the commit output row indexed by the instruction's program slot, so commits keep slot order whichever checker produced them. Every hold entry is a two-state machine. In HS_EMPTY it takes the transition "allocate" to HS_HELD when a lane asks to park its result there. In HS_HELD it takes the transition "consume" back to HS_EMPTY when a checker judges that entry.

Top module: `redundancy_voter`

## Requirements
- R1: While reset is low and after its release with no traffic, every output bit (cmt_vld, cmt_data, cmt_seq, cmt_err, cmt_unc) is zero and all hold entries are empty.
- R2: With tmr_mode=0 (duplicate), an enabled checker fires when copies A and B are present. It commits copy A's data and sequence, and raises cmt_err when the copies differ in data, slot tag or sequence tag. A commit is made even on mismatch, and cmt_unc stays 0.
- R3: With tmr_mode=1 (triple), an enabled checker fires when copies A, B and C are all present. It commits the value that at least two copies share, preferring A when A matches either of the others. cmt_err is set unless all three copies agree.
- R4: In triple mode, when all three copies differ, nothing is committed. The row of copy A's slot shows cmt_vld=0, cmt_err=1, cmt_unc=1, with data and sequence fields zero.
- R5: route_src holds 3 bits per copy, with 9 bits per checker k at [9k+8:9k]: A in bits 2:0, B in 5:3, C in 8:6. A code v from 0 to 3 selects live lane v, and a code from 4 to 7 selects hold entry v-4. A checker whose route_chk_en bit is 0, or that lacks a required copy (lane not valid, or entry empty), produces nothing.
- R6: A lane with exe_vld and route_hold set parks its result (data, slot, sequence) in the lowest-numbered empty hold entry, with lanes served in ascending order. Entries freed in the same cycle are not reused. The entry can be selected from the next cycle on. A request that finds no empty entry is dropped.
- R7: A hold entry used by a checker that fires returns to empty. A later selection of that entry therefore counts as an absent copy.
- R8: Commits appear one cycle after their inputs, on the row whose index equals the committed copy's 2-bit slot tag. When two firing checkers map to the same slot, the lower-numbered checker wins.
- R9: In duplicate mode, copy C's select is ignored. It neither gates firing nor frees the hold entry it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_mode | input | 1 | 0 duplicate compare, 1 triple vote |
| exe_vld | input | LANES | Lane result valid |
| exe_data | input | LANES*DATA_W | Lane result data, lane l at [l*DATA_W +: DATA_W] |
| exe_slot | input | LANES*SLOT_W | Program slot tag per lane |
| exe_seq | input | LANES*SEQ_W | Bundle sequence tag per lane |
| route_chk_en | input | CHK | Checker enable |
| route_src | input | CHK*3*SRC_W | Copy source selects per checker |
| route_hold | input | LANES | Park the lane result in the hold store |
| cmt_vld | output | SLOTS | Commit valid per program slot |
| cmt_data | output | SLOTS*DATA_W | Committed data per slot |
| cmt_seq | output | SLOTS*SEQ_W | Committed bundle sequence per slot |
| cmt_err | output | SLOTS | Copies disagreed for this slot |
| cmt_unc | output | SLOTS | Triple vote without a majority |

## Verification
Every commit and error row is due one rising edge after the cycle whose lanes and routing produced it. The bench drives a cycle's inputs at the falling edge and pushes that cycle's expected output row into a queue. A monitor pops the row and compares it 1 ns after the next rising edge. A parked result affects only later cycles, so hold and free behaviour is checked by spreading a test over consecutive driven cycles. Each of those cycles has its own expected row.

// File: rtl/rv_pkg.sv
package rv_pkg;
    typedef enum logic {
        MODE_DUP = 1'b0,
        MODE_TMR = 1'b1
    } vote_mode_e;

    typedef enum logic {
        HS_EMPTY = 1'b0,
        HS_HELD  = 1'b1
    } hold_state_e;

    typedef enum logic [1:0] {
        PICK_A    = 2'd0,
        PICK_B    = 2'd1,
        PICK_NONE = 2'd2
    } pick_e;
endpackage

// File: rtl/rv_route.sv
module rv_route #(
    parameter int LANES  = 4,
    parameter int HOLD   = 4,
    parameter int DATA_W = 32,
    parameter int SLOT_W = 2,
    parameter int SEQ_W  = 4,
    parameter int SRC_W  = 3
) (
    input  logic [SRC_W-1:0]        sel,
    input  logic [LANES-1:0]        lane_vld,
    input  logic [LANES*DATA_W-1:0] lane_data,
    input  logic [LANES*SLOT_W-1:0] lane_slot,
    input  logic [LANES*SEQ_W-1:0]  lane_seq,
    input  logic [HOLD-1:0]         ent_vld,
    input  logic [HOLD*DATA_W-1:0]  ent_data,
    input  logic [HOLD*SLOT_W-1:0]  ent_slot,
    input  logic [HOLD*SEQ_W-1:0]   ent_seq,
    output logic                    o_vld,
    output logic [DATA_W-1:0]       o_data,
    output logic [SLOT_W-1:0]       o_slot,
    output logic [SEQ_W-1:0]        o_seq
);
    always_comb begin
        o_vld  = 1'b0;
        o_data = '0;
        o_slot = '0;
        o_seq  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == SRC_W'(i)) begin
                o_vld  = lane_vld[i];
                o_data = lane_data[i*DATA_W +: DATA_W];
                o_slot = lane_slot[i*SLOT_W +: SLOT_W];
                o_seq  = lane_seq[i*SEQ_W +: SEQ_W];
            end
        end
        for (int e = 0; e < HOLD; e++) begin
            if (sel == SRC_W'(LANES + e)) begin
                o_vld  = ent_vld[e];
                o_data = ent_data[e*DATA_W +: DATA_W];
                o_slot = ent_slot[e*SLOT_W +: SLOT_W];
                o_seq  = ent_seq[e*SEQ_W +: SEQ_W];
            end
        end
    end
endmodule

// File: rtl/rv_judge.sv
module rv_judge
    import rv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOT_W = 2,
    parameter int SEQ_W  = 4
) (
    input  logic                  mode,
    input  logic [2:0]            cp_vld,
    input  logic [3*DATA_W-1:0]   cp_data,
    input  logic [3*SLOT_W-1:0]   cp_slot,
    input  logic [3*SEQ_W-1:0]    cp_seq,
    output logic                  fire,
    output logic                  out_vld,
    output logic [DATA_W-1:0]     out_data,
    output logic [SLOT_W-1:0]     out_slot,
    output logic [SEQ_W-1:0]      out_seq,
    output logic                  out_err,
    output logic                  out_unc
);
    localparam int KEY_W = DATA_W + SLOT_W + SEQ_W;

    logic [KEY_W-1:0] key [3];
    logic             eq_ab, eq_ac, eq_bc;
    pick_e            pick;

    always_comb begin
        for (int c = 0; c < 3; c++) begin
            key[c] = {cp_data[c*DATA_W +: DATA_W], cp_slot[c*SLOT_W +: SLOT_W],
                      cp_seq[c*SEQ_W +: SEQ_W]};
        end
    end

    assign eq_ab = (key[0] == key[1]);
    assign eq_ac = (key[0] == key[2]);
    assign eq_bc = (key[1] == key[2]);

    always_comb begin
        fire    = 1'b0;
        pick    = PICK_A;
        out_err = 1'b0;
        out_unc = 1'b0;
        unique case (vote_mode_e'(mode))
            MODE_DUP: begin
                fire    = cp_vld[0] & cp_vld[1];
                out_err = fire & ~eq_ab;
            end
            MODE_TMR: begin
                fire = &cp_vld;
                if (eq_ab | eq_ac)  pick = PICK_A;
                else if (eq_bc)     pick = PICK_B;
                else                pick = PICK_NONE;
                out_err = fire & ~(eq_ab & eq_bc);
                out_unc = fire & (pick == PICK_NONE);
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (pick)
            PICK_B: begin
                out_data = cp_data[DATA_W +: DATA_W];
                out_slot = cp_slot[SLOT_W +: SLOT_W];
                out_seq  = cp_seq[SEQ_W +: SEQ_W];
            end
            default: begin
                out_data = cp_data[0 +: DATA_W];
                out_slot = cp_slot[0 +: SLOT_W];
                out_seq  = cp_seq[0 +: SEQ_W];
            end
        endcase
        out_vld = fire & (pick != PICK_NONE);
    end
endmodule

// File: rtl/rv_hold_store.sv
module rv_hold_store
    import rv_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int HOLD   = 4,
    parameter int DATA_W = 32,
    parameter int SLOT_W = 2,
    parameter int SEQ_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_vld,
    input  logic [LANES*DATA_W-1:0] lane_data,
    input  logic [LANES*SLOT_W-1:0] lane_slot,
    input  logic [LANES*SEQ_W-1:0]  lane_seq,
    input  logic [LANES-1:0]        hold_req,
    input  logic [HOLD-1:0]         consume,
    output logic [HOLD-1:0]         ent_vld,
    output logic [HOLD*DATA_W-1:0]  ent_data,
    output logic [HOLD*SLOT_W-1:0]  ent_slot,
    output logic [HOLD*SEQ_W-1:0]   ent_seq
);
    logic [HOLD-1:0]  alloc;
    logic [LANES-1:0] src_mask [HOLD];

    // Lowest empty entry per request, lanes in ascending order.
    always_comb begin
        logic [HOLD-1:0] taken;
        logic            placed;
        taken = '0;
        alloc = '0;
        for (int e = 0; e < HOLD; e++) src_mask[e] = '0;
        for (int l = 0; l < LANES; l++) begin
            placed = 1'b0;
            for (int e = 0; e < HOLD; e++) begin
                if (!placed && hold_req[l] && lane_vld[l] && !ent_vld[e] && !taken[e]) begin
                    taken[e]       = 1'b1;
                    alloc[e]       = 1'b1;
                    src_mask[e][l] = 1'b1;
                    placed         = 1'b1;
                end
            end
        end
    end

    for (genvar e = 0; e < HOLD; e++) begin : g_ent
        hold_state_e        st_q;
        logic [DATA_W-1:0]  d_q, d_nx;
        logic [SLOT_W-1:0]  s_q, s_nx;
        logic [SEQ_W-1:0]   q_q, q_nx;

        always_comb begin
            d_nx = d_q;
            s_nx = s_q;
            q_nx = q_q;
            for (int l = 0; l < LANES; l++) begin
                if (src_mask[e][l]) begin
                    d_nx = lane_data[l*DATA_W +: DATA_W];
                    s_nx = lane_slot[l*SLOT_W +: SLOT_W];
                    q_nx = lane_seq[l*SEQ_W +: SEQ_W];
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= HS_EMPTY;
            end else begin
                unique case (st_q)
                    HS_EMPTY: if (alloc[e])   st_q <= HS_HELD;
                    HS_HELD:  if (consume[e]) st_q <= HS_EMPTY;
                    default:                  st_q <= HS_EMPTY;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                s_q <= '0;
                q_q <= '0;
            end else begin
                d_q <= d_nx;
                s_q <= s_nx;
                q_q <= q_nx;
            end
        end

        assign ent_vld[e]                   = (st_q == HS_HELD);
        assign ent_data[e*DATA_W +: DATA_W] = d_q;
        assign ent_slot[e*SLOT_W +: SLOT_W] = s_q;
        assign ent_seq[e*SEQ_W +: SEQ_W]    = q_q;

        assert_consume_only_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            consume[e] |-> st_q == HS_HELD)
            else $error("hold entry freed while empty");

        assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(src_mask[e]))
            else $error("two lanes parked into one hold entry");
    end
endmodule

// File: rtl/redundancy_voter.sv
module redundancy_voter
    import rv_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int SLOTS  = 4,
    parameter int CHK    = 4,
    parameter int HOLD   = 4,
    parameter int DATA_W = 32,
    parameter int SEQ_W  = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int SRC_W  = $clog2(LANES + HOLD)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tmr_mode,
    input  logic [LANES-1:0]          exe_vld,
    input  logic [LANES*DATA_W-1:0]   exe_data,
    input  logic [LANES*SLOT_W-1:0]   exe_slot,
    input  logic [LANES*SEQ_W-1:0]    exe_seq,
    input  logic [CHK-1:0]            route_chk_en,
    input  logic [CHK*3*SRC_W-1:0]    route_src,
    input  logic [LANES-1:0]          route_hold,
    output logic [SLOTS-1:0]          cmt_vld,
    output logic [SLOTS*DATA_W-1:0]   cmt_data,
    output logic [SLOTS*SEQ_W-1:0]    cmt_seq,
    output logic [SLOTS-1:0]          cmt_err,
    output logic [SLOTS-1:0]          cmt_unc
);
    localparam int COPIES = 3 * CHK;

    logic [HOLD-1:0]            ent_vld;
    logic [HOLD*DATA_W-1:0]     ent_data;
    logic [HOLD*SLOT_W-1:0]     ent_slot;
    logic [HOLD*SEQ_W-1:0]      ent_seq;
    logic [HOLD-1:0]            consume;

    logic [COPIES-1:0]          cp_vld;
    logic [COPIES*DATA_W-1:0]   cp_data;
    logic [COPIES*SLOT_W-1:0]   cp_slot;
    logic [COPIES*SEQ_W-1:0]    cp_seq;

    logic [CHK-1:0]             j_fire, j_vld, j_err, j_unc, act;
    logic [CHK*DATA_W-1:0]      j_data;
    logic [CHK*SLOT_W-1:0]      j_slot;
    logic [CHK*SEQ_W-1:0]       j_seq;

    logic [SLOTS-1:0]           n_vld, n_err, n_unc;
    logic [SLOTS*DATA_W-1:0]    n_data;
    logic [SLOTS*SEQ_W-1:0]     n_seq;

    rv_hold_store #(
        .LANES(LANES), .HOLD(HOLD), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .SEQ_W(SEQ_W)
    ) u_hold (
        .clk(clk), .rst_n(rst_n),
        .lane_vld(exe_vld), .lane_data(exe_data), .lane_slot(exe_slot), .lane_seq(exe_seq),
        .hold_req(route_hold), .consume(consume),
        .ent_vld(ent_vld), .ent_data(ent_data), .ent_slot(ent_slot), .ent_seq(ent_seq)
    );

    for (genvar i = 0; i < COPIES; i++) begin : g_route
        rv_route #(
            .LANES(LANES), .HOLD(HOLD), .DATA_W(DATA_W),
            .SLOT_W(SLOT_W), .SEQ_W(SEQ_W), .SRC_W(SRC_W)
        ) u_route (
            .sel(route_src[i*SRC_W +: SRC_W]),
            .lane_vld(exe_vld), .lane_data(exe_data), .lane_slot(exe_slot), .lane_seq(exe_seq),
            .ent_vld(ent_vld), .ent_data(ent_data), .ent_slot(ent_slot), .ent_seq(ent_seq),
            .o_vld(cp_vld[i]), .o_data(cp_data[i*DATA_W +: DATA_W]),
            .o_slot(cp_slot[i*SLOT_W +: SLOT_W]), .o_seq(cp_seq[i*SEQ_W +: SEQ_W])
        );
    end

    for (genvar k = 0; k < CHK; k++) begin : g_judge
        rv_judge #(
            .DATA_W(DATA_W), .SLOT_W(SLOT_W), .SEQ_W(SEQ_W)
        ) u_judge (
            .mode(tmr_mode),
            .cp_vld(cp_vld[k*3 +: 3]),
            .cp_data(cp_data[k*3*DATA_W +: 3*DATA_W]),
            .cp_slot(cp_slot[k*3*SLOT_W +: 3*SLOT_W]),
            .cp_seq(cp_seq[k*3*SEQ_W +: 3*SEQ_W]),
            .fire(j_fire[k]), .out_vld(j_vld[k]),
            .out_data(j_data[k*DATA_W +: DATA_W]),
            .out_slot(j_slot[k*SLOT_W +: SLOT_W]),
            .out_seq(j_seq[k*SEQ_W +: SEQ_W]),
            .out_err(j_err[k]), .out_unc(j_unc[k])
        );
        assign act[k] = route_chk_en[k] & j_fire[k];
    end

    // Entries named by a firing checker are released; copy C only counts when voting.
    always_comb begin
        consume = '0;
        for (int k = 0; k < CHK; k++) begin
            for (int c = 0; c < 3; c++) begin
                if (act[k] && (c < 2 || tmr_mode)) begin
                    for (int e = 0; e < HOLD; e++) begin
                        if (route_src[(k*3+c)*SRC_W +: SRC_W] == SRC_W'(LANES + e))
                            consume[e] = 1'b1;
                    end
                end
            end
        end
    end

    // Map checker results onto program slot rows; lowest checker claims a row first.
    always_comb begin
        logic [SLOTS-1:0] claimed;
        claimed = '0;
        n_vld   = '0;
        n_data  = '0;
        n_seq   = '0;
        n_err   = '0;
        n_unc   = '0;
        for (int k = 0; k < CHK; k++) begin
            if (act[k]) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (j_slot[k*SLOT_W +: SLOT_W] == SLOT_W'(s) && !claimed[s]) begin
                        claimed[s] = 1'b1;
                        n_vld[s]   = j_vld[k];
                        n_err[s]   = j_err[k];
                        n_unc[s]   = j_unc[k];
                        if (j_vld[k]) begin
                            n_data[s*DATA_W +: DATA_W] = j_data[k*DATA_W +: DATA_W];
                            n_seq[s*SEQ_W +: SEQ_W]    = j_seq[k*SEQ_W +: SEQ_W];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmt_vld  <= '0;
            cmt_data <= '0;
            cmt_seq  <= '0;
            cmt_err  <= '0;
            cmt_unc  <= '0;
        end else begin
            cmt_vld  <= n_vld;
            cmt_data <= n_data;
            cmt_seq  <= n_seq;
            cmt_err  <= n_err;
            cmt_unc  <= n_unc;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_chk
        assert_unc_blocks_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cmt_unc[s] |-> (!cmt_vld[s] && cmt_err[s]))
            else $error("uncorrectable row carries a commit");
    end

    assert_dup_never_unc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_mode |=> (cmt_unc == '0))
        else $error("uncorrectable flag in duplicate mode");

    assert_commit_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|route_chk_en) == 1'b0 |=> (cmt_vld == '0 && cmt_err == '0))
        else $error("commit without an enabled checker");
endmodule

// File: tb/test_redundancy_voter.sv
module test_redundancy_voter;
    typedef struct packed {
        logic [3:0]   vld;
        logic [127:0] data;
        logic [15:0]  seq;
        logic [3:0]   err;
        logic [3:0]   unc;
    } row_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tmr_mode = 1'b0;
    logic [3:0]   exe_vld = '0;
    logic [127:0] exe_data = '0;
    logic [7:0]   exe_slot = '0;
    logic [15:0]  exe_seq = '0;
    logic [3:0]   route_chk_en = '0;
    logic [35:0]  route_src = '0;
    logic [3:0]   route_hold = '0;
    logic [3:0]   cmt_vld, cmt_err, cmt_unc;
    logic [127:0] cmt_data;
    logic [15:0]  cmt_seq;

    int checks = 0;
    int errors = 0;
    row_t  exp_q[$];
    string tag_q[$];
    row_t  cur;

    always #2 clk = ~clk;

    redundancy_voter i_redundancy_voter (
        .clk(clk), .rst_n(rst_n), .tmr_mode(tmr_mode),
        .exe_vld(exe_vld), .exe_data(exe_data), .exe_slot(exe_slot), .exe_seq(exe_seq),
        .route_chk_en(route_chk_en), .route_src(route_src), .route_hold(route_hold),
        .cmt_vld(cmt_vld), .cmt_data(cmt_data), .cmt_seq(cmt_seq),
        .cmt_err(cmt_err), .cmt_unc(cmt_unc)
    );

    task automatic compare(string tag, row_t exp);
        row_t act;
        act = {cmt_vld, cmt_data, cmt_seq, cmt_err, cmt_unc};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: each driven cycle's row is due after the next rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) compare(tag_q.pop_front(), exp_q.pop_front());
    end

    task automatic cyc_begin(bit m);
        @(negedge clk);
        tmr_mode     = m;
        exe_vld      = '0;
        exe_data     = '0;
        exe_slot     = '0;
        exe_seq      = '0;
        route_chk_en = '0;
        route_src    = '0;
        route_hold   = '0;
        cur          = '0;
    endtask

    task automatic lane(int l, logic [31:0] d, int s, int q);
        exe_vld[l]           = 1'b1;
        exe_data[l*32 +: 32] = d;
        exe_slot[l*2 +: 2]   = s[1:0];
        exe_seq[l*4 +: 4]    = q[3:0];
    endtask

    task automatic chk(int k, int a, int b, int c);
        route_chk_en[k]     = 1'b1;
        route_src[k*9 +: 9] = {c[2:0], b[2:0], a[2:0]};
    endtask

    task automatic want(int s, logic [31:0] d, int q, bit v, bit er, bit un);
        cur.vld[s]         = v;
        cur.data[s*32 +: 32] = d;
        cur.seq[s*4 +: 4]  = q[3:0];
        cur.err[s]         = er;
        cur.unc[s]         = un;
    endtask

    task automatic cyc_end(string tag);
        exp_q.push_back(cur);
        tag_q.push_back(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 outputs in reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 outputs after reset", '0);

        // duplicate mode
        cyc_begin(0); lane(0, 32'h11, 2, 3); lane(1, 32'h11, 2, 3); chk(0, 0, 1, 0);
        want(2, 32'h11, 3, 1, 0, 0); cyc_end("R2 dup agree, R8 row by slot");
        cyc_begin(0); lane(0, 32'h22, 1, 0); lane(1, 32'h23, 1, 0); chk(0, 0, 1, 0);
        want(1, 32'h22, 0, 1, 1, 0); cyc_end("R2 dup data mismatch");
        cyc_begin(0); lane(0, 32'h44, 0, 1); lane(1, 32'h44, 0, 2); chk(0, 0, 1, 0);
        want(0, 32'h44, 1, 1, 1, 0); cyc_end("R2 dup sequence tag mismatch");
        cyc_begin(0); lane(0, 32'h33, 3, 2); lane(1, 32'h33, 3, 2); chk(0, 0, 1, 2);
        want(3, 32'h33, 2, 1, 0, 0); cyc_end("R9 dup ignores absent copy C");
        cyc_begin(0); lane(0, 32'h33, 3, 2); chk(0, 0, 1, 0);
        cyc_end("R5 absent copy B gives nothing");
        cyc_begin(0); lane(0, 32'h33, 3, 2); lane(1, 32'h33, 3, 2);
        cyc_end("R5 disabled checker gives nothing");

        // triple mode
        cyc_begin(1); lane(0, 5, 0, 0); lane(1, 9, 0, 0); lane(2, 5, 0, 0); chk(0, 0, 1, 2);
        want(0, 5, 0, 1, 1, 0); cyc_end("R3 vote A and C outvote B");
        cyc_begin(1); lane(0, 6, 1, 0); lane(1, 8, 1, 0); lane(2, 8, 1, 0); chk(0, 0, 1, 2);
        want(1, 8, 0, 1, 1, 0); cyc_end("R3 vote B and C outvote A");
        cyc_begin(1); lane(0, 7, 3, 0); lane(1, 7, 3, 0); lane(2, 7, 3, 0); chk(0, 0, 1, 2);
        want(3, 7, 0, 1, 0, 0); cyc_end("R3 vote unanimous");
        cyc_begin(1); lane(0, 1, 0, 0); lane(1, 2, 0, 0); lane(2, 3, 0, 0); chk(0, 0, 1, 2);
        want(0, 0, 0, 0, 1, 1); cyc_end("R4 three-way disagreement");
        cyc_begin(1); lane(0, 4, 0, 0); lane(1, 4, 0, 0); chk(0, 0, 1, 2);
        cyc_end("R5 vote missing copy C");

        // hold store
        cyc_begin(0); lane(0, 32'h40, 1, 5); route_hold[0] = 1'b1;
        cyc_end("R6 park gives nothing");
        cyc_begin(0); lane(1, 32'h40, 1, 5); chk(0, 4, 1, 0);
        want(1, 32'h40, 5, 1, 0, 0); cyc_end("R6 parked copy paired later");
        cyc_begin(0); lane(1, 32'h40, 1, 5); chk(0, 4, 1, 0);
        cyc_end("R7 consumed entry is empty");
        cyc_begin(0); lane(0, 32'hA0, 0, 1); lane(2, 32'hA2, 2, 1);
        route_hold[0] = 1'b1; route_hold[2] = 1'b1;
        cyc_end("R6 two parks");
        cyc_begin(0); lane(3, 32'hA2, 2, 1); chk(0, 5, 3, 0); lane(1, 32'hA0, 0, 1); chk(1, 4, 1, 0);
        want(2, 32'hA2, 1, 1, 0, 0); want(0, 32'hA0, 1, 1, 0, 0);
        cyc_end("R6 lane order fills entries, R8 slot order");
        cyc_begin(0); lane(0, 32'h31, 3, 0); lane(1, 32'h31, 3, 0); lane(2, 32'h32, 3, 0);
        lane(3, 32'h32, 3, 0); chk(0, 0, 1, 0); chk(1, 2, 3, 0);
        want(3, 32'h31, 0, 1, 0, 0); cyc_end("R8 lower checker wins slot");
        cyc_begin(0); lane(0, 32'h55, 0, 2); route_hold[0] = 1'b1;
        cyc_end("R9 park for dup copy C");
        cyc_begin(0); lane(1, 32'h55, 0, 2); lane(2, 32'h55, 0, 2); chk(0, 1, 2, 4);
        want(0, 32'h55, 2, 1, 0, 0); cyc_end("R9 dup with C naming entry");
        cyc_begin(0); lane(1, 32'h55, 0, 2); chk(0, 4, 1, 0);
        want(0, 32'h55, 2, 1, 0, 0); cyc_end("R9 entry not freed by C in dup");
        cyc_begin(0);
        for (int l = 0; l < 4; l++) begin lane(l, 32'hB0 + l, l, 6); route_hold[l] = 1'b1; end
        cyc_end("R6 fill store");
        cyc_begin(0); lane(0, 32'hCC, 0, 6); route_hold[0] = 1'b1;
        cyc_end("R6 park into full store");
        cyc_begin(0);
        for (int k = 0; k < 4; k++) begin
            lane(k, 32'hB0 + k, k, 6); chk(k, 4 + k, k, 0); want(k, 32'hB0 + k, 6, 1, 0, 0);
        end
        cyc_end("R6 full store contents intact");
        cyc_begin(0); lane(0, 32'hCC, 0, 6); chk(0, 4, 0, 0);
        cyc_end("R6 dropped park, R7 freed entry");
        cyc_begin(0); lane(0, 32'h66, 2, 3); route_hold[0] = 1'b1;
        cyc_end("R7 park for vote");
        cyc_begin(1); lane(1, 32'h66, 2, 3); lane(2, 32'h66, 2, 3); chk(0, 1, 2, 4);
        want(2, 32'h66, 3, 1, 0, 0); cyc_end("R3 vote with parked C");
        cyc_begin(1); lane(1, 32'h66, 2, 3); lane(2, 32'h66, 2, 3); chk(0, 1, 2, 4);
        cyc_end("R7 vote frees copy C entry");

        cyc_begin(0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule